// File: doc/BRIEF.md
# Peripheral Reset and Clock-Stop Control Bank

This block is a small memory-mapped register bank that owns the reset lines and the clock-stop controls of 64 peripherals. Each group of 64 control bits is kept as two 32-bit words: a lower word for indices 0 to 31 and an upper word for indices 32 to 63. Each word has two write addresses. A write to the base address sets bits, and a write to the address four bytes above it clears bits. Software can therefore change one peripheral's control bit in a single write, with no read-modify-write sequence that another agent could interleave with.

The bank sits on a simple single-cycle register bus with address, write data, write strobe and read data. It drives one reset output per peripheral. It also drives one clock-enable output per peripheral that reads 1 when the clock should run. A fixed per-bit polarity hides the one control bit whose stored sense is inverted. Bit 31 of the lower clock-stop word is not a clock control. It selects a divide-by-13 mode for an auxiliary serial-port reference clock and has its own output. Gating cells and clock sources are outside this block.

Top module: `periph_ctl_bank`

## Requirements
- R1: After power-on reset all 64 reset outputs are 1 and all 64 clock-enable outputs are 0. The divide-by-13 output is 0. Reading 0x080 returns 0x7FFFBFFF and reading 0x040 returns 0xFFFFFFFF.
- R2: A write to a set address (0x040, 0x050, 0x080, 0x090) sets every bit of that word whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A write to a clear address (0x044, 0x054, 0x084, 0x094) clears every bit of that word whose write-data bit is 1. Bits written as 0 keep their value.
- R4: Peripheral index i maps to bit i of the lower word (0x040 for reset, 0x080 for clock-stop) when i < 32, and to bit i-32 of the upper word (0x050 or 0x090) otherwise. Reset output i is that reset bit, and 1 holds the peripheral in reset.
- R5: Clock-enable output i is the inverse of clock-stop bit i, except index 14, where a stored 1 means the clock runs and the enable equals the stored bit.
- R6: Bit 31 of word 0x080 drives the divide-by-13 output directly. Clock-enable output 31 stays 0 whatever that bit holds.
- R7: A read of a word's set address or its clear address returns the current word. A read of any other address returns 0.
- R8: A write with the strobe low, or a write to any address outside the eight listed, changes no word and no output.
- R9: Outputs take a written value at the first rising clock edge that samples the write strobe high. Before that edge they show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data: mask of bits to set or clear |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| periph_rst_o | output | 64 | Per-peripheral reset, 1 = held in reset |
| periph_clk_en_o | output | 64 | Per-peripheral clock enable, 1 = clock runs |
| uart_div13_o | output | 1 | Divide-by-13 select for the auxiliary serial reference clock |

## Verification
A write presented with the strobe high is registered at the next rising edge, so every reset, clock-enable and mode output is due exactly one cycle after the write is presented. Read data is combinational and is due in the same cycle as the address. The bench drives each access at a falling edge and checks the outputs at the next falling edge, which falls half a period after the registering edge. For R9 it also samples once just before that edge to confirm that the old value is still present. Reads are checked one nanosecond after the address is applied, and no clock edge comes in between.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int NUM_WORDS = 4;
  localparam int NUM_PERIPH = 64;

  // word order: reset low, reset high, clock-stop low, clock-stop high
  typedef enum logic [1:0] {
    W_RST_LO  = 2'd0,
    W_RST_HI  = 2'd1,
    W_STOP_LO = 2'd2,
    W_STOP_HI = 2'd3
  } word_e;

  localparam logic [ADDR_W-1:0] RST_BASE  = 12'h040;
  localparam logic [ADDR_W-1:0] STOP_BASE = 12'h080;
  localparam logic [ADDR_W-1:0] HI_STEP   = 12'h010;
  localparam logic [ADDR_W-1:0] CLR_OFF   = 12'h004;

  function automatic logic [ADDR_W-1:0] word_base(input int w);
    logic [ADDR_W-1:0] b;
    b = (w < 2) ? RST_BASE : STOP_BASE;
    if ((w % 2) == 1) b = b + HI_STEP;
    return b;
  endfunction
endpackage

// File: rtl/pcb_rst_sync.sv
module pcb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pcb_decode.sv
module pcb_decode
  import pcb_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NW = NUM_WORDS
) (
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  logic [NW*DW-1:0] words,
  output logic [NW-1:0]    set_hit,
  output logic [NW-1:0]    clr_hit,
  output logic [DW-1:0]    rdata
);
  logic [NW-1:0] rd_hit;

  for (genvar w = 0; w < NW; w++) begin : g_dec
    localparam logic [AW-1:0] BASE = AW'(word_base(w));
    localparam logic [AW-1:0] CLRA = AW'(word_base(w) + CLR_OFF);
    assign set_hit[w] = we && (addr == BASE);
    assign clr_hit[w] = we && (addr == CLRA);
    assign rd_hit[w]  = (addr == BASE) || (addr == CLRA);
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NW; w++) begin
      if (rd_hit[w]) rdata = rdata | words[w*DW +: DW];
    end
  end
endmodule

// File: rtl/pcb_sc_word.sv
module pcb_sc_word #(
  parameter int             DW      = 32,
  parameter logic [DW-1:0]  RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_nxt;
  logic          q_upd;

  always_comb begin
    q_upd = set_en || clr_en;
    q_nxt = q;
    if (set_en)      q_nxt = q | mask;
    else if (clr_en) q_nxt = q & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (q_upd) q <= q_nxt;
  end
endmodule

// File: rtl/pcb_clk_pol.sv
module pcb_clk_pol #(
  parameter int             N         = 64,
  parameter logic [N-1:0]   INV_MASK  = '0,
  parameter logic [N-1:0]   MODE_MASK = '0
) (
  input  logic [N-1:0] stop,
  output logic [N-1:0] en,
  output logic         mode_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (MODE_MASK[i]) begin : g_mode
      assign en[i] = 1'b0;
    end else if (INV_MASK[i]) begin : g_inv
      assign en[i] = stop[i];
    end else begin : g_norm
      assign en[i] = ~stop[i];
    end
  end

  assign mode_o = |(stop & MODE_MASK);
endmodule

// File: rtl/periph_ctl_bank.sv
module periph_ctl_bank
  import pcb_pkg::*;
#(
  parameter logic [NUM_PERIPH-1:0] INV_MASK  = 64'h0000_0000_0000_4000,
  parameter logic [NUM_PERIPH-1:0] MODE_MASK = 64'h0000_0000_8000_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  bus_we,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [NUM_PERIPH-1:0] periph_rst_o,
  output logic [NUM_PERIPH-1:0] periph_clk_en_o,
  output logic                  uart_div13_o
);
  localparam logic [NUM_PERIPH-1:0] STOP_INIT = ~(INV_MASK | MODE_MASK);
  localparam logic [NUM_PERIPH-1:0] RST_INIT  = '1;

  logic                        rst_sync_n;
  logic [NUM_WORDS-1:0]        set_hit;
  logic [NUM_WORDS-1:0]        clr_hit;
  logic [NUM_WORDS*DATA_W-1:0] words;
  logic [NUM_PERIPH-1:0]       stop_bits;

  pcb_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcb_decode #(.AW(ADDR_W), .DW(DATA_W), .NW(NUM_WORDS)) u_decode (
    .addr    (bus_addr),
    .we      (bus_we),
    .words   (words),
    .set_hit (set_hit),
    .clr_hit (clr_hit),
    .rdata   (bus_rdata)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    if (w < 2) begin : g_rst
      pcb_sc_word #(.DW(DATA_W), .RST_VAL(RST_INIT[w*DATA_W +: DATA_W])) u_word (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .set_en (set_hit[w]),
        .clr_en (clr_hit[w]),
        .mask   (bus_wdata),
        .q      (words[w*DATA_W +: DATA_W])
      );
    end else begin : g_stop
      pcb_sc_word #(.DW(DATA_W), .RST_VAL(STOP_INIT[(w-2)*DATA_W +: DATA_W])) u_word (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .set_en (set_hit[w]),
        .clr_en (clr_hit[w]),
        .mask   (bus_wdata),
        .q      (words[w*DATA_W +: DATA_W])
      );
    end
  end

  assign periph_rst_o = {words[W_RST_HI*DATA_W +: DATA_W], words[W_RST_LO*DATA_W +: DATA_W]};
  assign stop_bits    = {words[W_STOP_HI*DATA_W +: DATA_W], words[W_STOP_LO*DATA_W +: DATA_W]};

  pcb_clk_pol #(.N(NUM_PERIPH), .INV_MASK(INV_MASK), .MODE_MASK(MODE_MASK)) u_pol (
    .stop   (stop_bits),
    .en     (periph_clk_en_o),
    .mode_o (uart_div13_o)
  );
endmodule

// File: rtl/periph_ctl_bank_chk.sv
module periph_ctl_bank_chk
  import pcb_pkg::*;
(
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic                  bus_we,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [NUM_PERIPH-1:0] periph_rst_o,
  input logic [NUM_PERIPH-1:0] periph_clk_en_o,
  input logic                  uart_div13_o
);
  p_set_lo_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == RST_BASE) |=>
      periph_rst_o[31:0] == ($past(periph_rst_o[31:0]) | $past(bus_wdata)));

  p_clr_hi_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == (RST_BASE + HI_STEP + CLR_OFF)) |=>
      periph_rst_o[63:32] == ($past(periph_rst_o[63:32]) & ~$past(bus_wdata)));

  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == STOP_BASE && bus_wdata[0]) |=> !periph_clk_en_o[0]);

  p_inv_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == STOP_BASE && bus_wdata[14]) |=> periph_clk_en_o[14]);

  p_mode_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == STOP_BASE && bus_wdata[31]) |=>
      (uart_div13_o && !periph_clk_en_o[31]));

  p_read_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == (RST_BASE + CLR_OFF)) |-> bus_rdata == periph_rst_o[31:0]);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_we |=> ($stable(periph_rst_o) && $stable(periph_clk_en_o) && $stable(uart_div13_o)));
endmodule

bind periph_ctl_bank periph_ctl_bank_chk u_chk (
  .clk             (clk),
  .rst_sync_n      (rst_sync_n),
  .bus_addr        (bus_addr),
  .bus_wdata       (bus_wdata),
  .bus_we          (bus_we),
  .bus_rdata       (bus_rdata),
  .periph_rst_o    (periph_rst_o),
  .periph_clk_en_o (periph_clk_en_o),
  .uart_div13_o    (uart_div13_o)
);

// File: tb/periph_ctl_bank_tb_top.sv
`timescale 1ns/1ps
module periph_ctl_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic [63:0] periph_rst_o;
  logic [63:0] periph_clk_en_o;
  logic        uart_div13_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] exp_w [4];

  always #10 clk = ~clk;

  periph_ctl_bank dut_i (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_we (bus_we), .bus_rdata (bus_rdata), .periph_rst_o (periph_rst_o),
    .periph_clk_en_o (periph_clk_en_o), .uart_div13_o (uart_div13_o)
  );

  function automatic logic [63:0] exp_en();
    logic [63:0] stop;
    logic [63:0] en;
    stop = {exp_w[3], exp_w[2]};
    for (int i = 0; i < 64; i++) begin
      if (i == 14)      en[i] = stop[i];
      else if (i == 31) en[i] = 1'b0;
      else              en[i] = ~stop[i];
    end
    return en;
  endfunction

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    check64({req, " reset outputs"}, periph_rst_o, {exp_w[1], exp_w[0]});
    check64({req, " clock enables"}, periph_clk_en_o, exp_en());
    check64({req, " div13"}, {63'd0, uart_div13_o}, {63'd0, exp_w[2][31]});
  endtask

  task automatic read_check(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1;
    check64({req, " read"}, {32'd0, bus_rdata}, {32'd0, exp});
  endtask

  // one write; model updated per R2/R3/R8, outputs checked one edge later (R9)
  task automatic do_write(string req, logic [11:0] a, logic [31:0] d, logic we);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = we;
    @(negedge clk);
    bus_we = 1'b0;
    if (we) begin
      for (int w = 0; w < 4; w++) begin
        logic [11:0] base;
        base = ((w < 2) ? 12'h040 : 12'h080) + ((w % 2) ? 12'h010 : 12'h000);
        if (a == base)          exp_w[w] = exp_w[w] | d;
        if (a == base + 12'h004) exp_w[w] = exp_w[w] & ~d;
      end
    end
    check_outputs(req);
  endtask

  task automatic t_reset_r1();
    exp_w[0] = 32'hFFFF_FFFF; exp_w[1] = 32'hFFFF_FFFF;
    exp_w[2] = 32'h7FFF_BFFF; exp_w[3] = 32'hFFFF_FFFF;
    check_outputs("R1");
    check64("R1 all clocks stopped", periph_clk_en_o, 64'd0);
    read_check("R1", 12'h080, 32'h7FFF_BFFF);
    read_check("R1", 12'h040, 32'hFFFF_FFFF);
  endtask

  task automatic t_set_clear_r2_r3();
    do_write("R3", 12'h044, 32'h0000_00F0, 1'b1);
    check64("R3 bits 4..7 out of reset", periph_rst_o[7:0], 64'h0F);
    do_write("R2", 12'h040, 32'h0000_0010, 1'b1);
    check64("R2 bit 4 only", periph_rst_o[7:0], 64'h1F);
    do_write("R3", 12'h094, 32'hA5A5_0000, 1'b1);
    do_write("R2", 12'h090, 32'h2000_0000, 1'b1);
  endtask

  task automatic t_index_r4();
    do_write("R4", 12'h054, 32'h0000_0001, 1'b1);
    check64("R4 index 32", {63'd0, periph_rst_o[32]}, 64'd0);
    do_write("R4", 12'h054, 32'h8000_0000, 1'b1);
    check64("R4 index 63", {63'd0, periph_rst_o[63]}, 64'd0);
    check64("R4 index 31 untouched", {63'd0, periph_rst_o[31]}, 64'd1);
  endtask

  task automatic t_polarity_r5();
    do_write("R5", 12'h084, 32'h0000_0001, 1'b1);
    check64("R5 index 0 runs", {63'd0, periph_clk_en_o[0]}, 64'd1);
    do_write("R5", 12'h080, 32'h0000_4000, 1'b1);
    check64("R5 index 14 set runs", {63'd0, periph_clk_en_o[14]}, 64'd1);
    do_write("R5", 12'h084, 32'h0000_4000, 1'b1);
    check64("R5 index 14 clear stops", {63'd0, periph_clk_en_o[14]}, 64'd0);
    do_write("R5", 12'h094, 32'h0000_0002, 1'b1);
    check64("R5 index 33 runs", {63'd0, periph_clk_en_o[33]}, 64'd1);
  endtask

  task automatic t_mode_r6();
    do_write("R6", 12'h080, 32'h8000_0000, 1'b1);
    check64("R6 div13 on", {63'd0, uart_div13_o}, 64'd1);
    check64("R6 enable 31 low", {63'd0, periph_clk_en_o[31]}, 64'd0);
    do_write("R6", 12'h084, 32'h8000_0000, 1'b1);
    check64("R6 enable 31 still low", {63'd0, periph_clk_en_o[31]}, 64'd0);
  endtask

  task automatic t_read_r7();
    read_check("R7 set addr", 12'h050, exp_w[1]);
    read_check("R7 clear addr", 12'h054, exp_w[1]);
    read_check("R7 clear addr", 12'h094, exp_w[3]);
    read_check("R7 unmapped", 12'h048, 32'd0);
  endtask

  task automatic t_ignore_r8();
    do_write("R8 strobe low", 12'h044, 32'hFFFF_FFFF, 1'b0);
    do_write("R8 unmapped", 12'h048, 32'hFFFF_FFFF, 1'b1);
    do_write("R8 unmapped", 12'h086, 32'hFFFF_FFFF, 1'b1);
    read_check("R8 state kept", 12'h040, exp_w[0]);
  endtask

  task automatic t_timing_r9();
    @(negedge clk);
    bus_addr = 12'h044; bus_wdata = 32'h0000_0100; bus_we = 1'b1;
    #8;
    check64("R9 old value before edge", {63'd0, periph_rst_o[8]}, 64'd1);
    @(negedge clk);
    bus_we = 1'b0;
    exp_w[0] = exp_w[0] & ~32'h0000_0100;
    check64("R9 new value after edge", {63'd0, periph_rst_o[8]}, 64'd0);
    check_outputs("R9");
  endtask

  task automatic t_patterns_r2_r3();
    logic [31:0] pats [3];
    pats[0] = 32'hDEAD_BEEF; pats[1] = 32'h1234_5678; pats[2] = 32'hF0F0_0F0F;
    for (int p = 0; p < 3; p++) begin
      do_write("R3 pattern", 12'h084, pats[p], 1'b1);
      do_write("R2 pattern", 12'h080, pats[(p + 1) % 3], 1'b1);
      do_write("R3 pattern", 12'h044, pats[p], 1'b1);
      do_write("R2 pattern", 12'h050, ~pats[p], 1'b1);
      read_check("R7 pattern", 12'h080, exp_w[2]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_r1();
    t_set_clear_r2_r3();
    t_index_r4();
    t_polarity_r5();
    t_mode_r6();
    t_read_r7();
    t_ignore_r8();
    t_timing_r9();
    t_patterns_r2_r3();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule